// File: doc/BRIEF.md
# PRBS Pattern Sync Monitor

This block watches a stream of recovered NRZ bits, one bit per clock in which `bitEn` is high. Without any trigger it keeps hunting for a pseudo-random test pattern. A mode input picks which pattern it hunts for. With `modeT1` low it looks for the 2^15-1 sequence used on E1 lines. With `modeT1` high it looks for the quasi-random signal source used on T1 lines. That source is a 2^20-1 sequence whose output may never hold more than 14 zeros in a row.

One output, `errOut`, reports two things. It stays high for as long as the monitor has not locked. It falls once lock is achieved. While locked, it rises for exactly one bit period for each received bit that differs from the pattern. When `cntEnable` is set, these after-lock errors are also added to a saturating error counter. The host samples that counter with a latch-and-clear strobe.

In hunt mode the monitor loads its predictor from the incoming bits, so it synchronises by itself. Once locked, the predictor runs free, so a single corrupted line bit produces one error and no more. Lock is dropped when errors become dense, and the hunt then restarts on its own.

Top module: `prbs_sync_mon`

## Requirements
- R1: After reset, `errOut` is 1 and `errCount` is 0.
- R2: With `modeT1`=0 the pattern obeys s[n] = s[n-14] XOR s[n-15]. Lock is declared on the 32nd consecutive correctly predicted bit, so `errOut` is still 1 after the first 31 bits following reset. With a clean pattern it is 0 after 47 bits.
- R3: With `modeT1`=1 the raw sequence obeys s[n] = s[n-17] XOR s[n-20]. The output bit is forced to 1 whenever the previous 14 output bits were all 0, and the raw recurrence keeps running on the unforced bit. The monitor is locked within 52 bits and flags no error across a forced one.
- R4: While locked, one corrupted input bit drives `errOut` high for exactly that one bit period. The next correct bit returns it to 0.
- R5: While locked, up to 5 errors within any 64-bit window keep the lock. The 6th error inside a 64-bit window drops it, and `errOut` then stays high.
- R6: After lock is lost, the hunt restarts with no outside action. Lock is declared again on the 32nd consecutive correct bit.
- R7: A stream of all zeros never produces lock in either mode. In mode 0, bits predicted from an all-zero history do not count toward lock.
- R8: When `cntEnable`=1, each after-lock error adds one to the internal counter. Errors during hunt are never counted, and nothing is counted when `cntEnable`=0. On a cycle with `latchStb`=1, `errCount` takes the counter value and the counter restarts from zero.
- R9: The counter saturates at its all-ones value (FFFFh with the default `CNT_W` of 16) and does not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one line bit is taken per cycle with `bitEn` high |
| rstN | input | 1 | Active-low synchronous reset |
| bitEn | input | 1 | Qualifies `rxData` as a new line bit |
| modeT1 | input | 1 | 0: 2^15-1 pattern, 1: quasi-random 2^20-1 pattern |
| rxData | input | 1 | Recovered NRZ data bit |
| cntEnable | input | 1 | Enables accumulation of after-lock errors |
| latchStb | input | 1 | Copies the counter to `errCount` and clears it |
| errOut | output | 1 | High when unlocked; one-bit pulse per error when locked |
| errCount | output | CNT_W | Last latched error count |

## Verification
The bench aims at the edges of the lock rule. It checks that lock is not declared on the 31st good bit and that it is declared on the 32nd, both at start-up and after a loss. A counter that is off by one would move one of those two edges. It injects exactly five errors and then six errors inside a 64-bit window. A window that is too long, too short or mis-counted would drop lock too early or hold it too long. A single flipped bit must give exactly one pulse; a monitor that kept reseeding from the line after lock would give three. In T1 mode the generator is placed just ahead of a long zero run, so the bench passes through forced ones. A design that skipped the forcing, or forced one bit late, would show error pulses there. The bench also sends all-zero input, which must never lock, and drives the counter past its maximum value.

// File: rtl/prbs_mon_pkg.sv
package prbs_mon_pkg;
  // register span holding enough history for the longer recurrence
  localparam int RAW_W  = 20;
  // E1 pattern: s[n] = s[n-14] ^ s[n-15]
  localparam int E1_LEN = 15;
  localparam int E1_TAP = 14;
  // T1 raw pattern: s[n] = s[n-17] ^ s[n-20]
  localparam int T1_LEN = 20;
  localparam int T1_TAP = 17;

  // strobes from the lock controller to the datapath
  typedef struct packed {
    logic hunt;      // predictor reseeds from the line and window is held clear
    logic countErr;  // add one to the error counter this cycle
  } monCtl_t;
endpackage

// File: rtl/prbs_mon_dpath.sv
module prbs_mon_dpath
  import prbs_mon_pkg::*;
#(
  parameter int WIN_LEN   = 64,
  parameter int LOSS_LIM  = 6,
  parameter int FORCE_RUN = 14,
  parameter int CNT_W     = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bitEn,
  input  logic             modeT1,
  input  logic             rxData,
  input  logic             latchStb,
  input  monCtl_t          ctl,
  output logic             bitErr,
  output logic             stateZero,
  output logic             winLoss,
  output logic [CNT_W-1:0] errCount
);
  localparam int WCNT_W = $clog2(WIN_LEN + 1);
  localparam int RUN_W  = $clog2(FORCE_RUN + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [RAW_W-1:0]   predSt;
  logic [RUN_W-1:0]   zeroRun;
  logic [WIN_LEN-1:0] errHist;
  logic [WCNT_W-1:0]  winCnt;
  logic [WCNT_W-1:0]  winNext;
  logic [CNT_W-1:0]   errCnt;
  logic               predBit;
  logic               forceOne;
  logic               expBit;
  logic               shiftIn;
  logic               runIn;
  logic               errQual;

  // prediction and comparison
  always_comb begin
    predBit   = modeT1 ? (predSt[T1_TAP-1] ^ predSt[T1_LEN-1])
                       : (predSt[E1_TAP-1] ^ predSt[E1_LEN-1]);
    stateZero = modeT1 ? (predSt[T1_LEN-1:0] == '0) : (predSt[E1_LEN-1:0] == '0);
    forceOne  = modeT1 && (zeroRun >= RUN_W'(FORCE_RUN));
    expBit    = forceOne | predBit;
    bitErr    = rxData ^ expBit;
    // hunting seeds from the line except on a forced bit, whose raw value is the prediction
    shiftIn   = (ctl.hunt && !forceOne) ? rxData : predBit;
    runIn     = ctl.hunt ? rxData : expBit;
    errQual   = !ctl.hunt && bitErr;
    winNext   = winCnt + WCNT_W'(errQual) - WCNT_W'(errHist[WIN_LEN-1]);
    winLoss   = errQual && (winNext >= WCNT_W'(LOSS_LIM));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      predSt  <= '0;
      zeroRun <= '0;
    end else if (bitEn) begin
      predSt <= {predSt[RAW_W-2:0], shiftIn};
      if (runIn)                              zeroRun <= '0;
      else if (zeroRun != RUN_W'(FORCE_RUN))  zeroRun <= zeroRun + 1'b1;
    end
  end

  // sliding error window
  always_ff @(posedge clk) begin
    if (!rstN) begin
      errHist <= '0;
      winCnt  <= '0;
    end else if (bitEn) begin
      if (ctl.hunt) begin
        errHist <= '0;
        winCnt  <= '0;
      end else begin
        errHist <= {errHist[WIN_LEN-2:0], errQual};
        winCnt  <= winNext;
      end
    end
  end

  // saturating error counter with latch-and-clear
  always_ff @(posedge clk) begin
    if (!rstN) begin
      errCnt   <= '0;
      errCount <= '0;
    end else if (latchStb) begin
      errCount <= errCnt;
      errCnt   <= ctl.countErr ? CNT_W'(1) : '0;
    end else if (ctl.countErr && errCnt != CNT_MAX) begin
      errCnt <= errCnt + 1'b1;
    end
  end

  assert_win_bound_R5: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.hunt |-> winCnt < WCNT_W'(LOSS_LIM));

  assert_sat_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (errCnt == CNT_MAX && !latchStb) |=> errCnt == CNT_MAX);

  assert_latch_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    (latchStb && !ctl.countErr) |=> errCnt == '0);

  assert_no_count_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!latchStb && !ctl.countErr) |=> $stable(errCnt));
endmodule

// File: rtl/prbs_mon_ctrl.sv
module prbs_mon_ctrl
  import prbs_mon_pkg::*;
#(
  parameter int LOCK_RUN = 32
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    bitEn,
  input  logic    cntEnable,
  input  logic    bitErr,
  input  logic    stateZero,
  input  logic    winLoss,
  output monCtl_t ctl,
  output logic    errOut
);
  localparam int GOOD_W = $clog2(LOCK_RUN);

  logic              lockedQ;
  logic              errFlagQ;
  logic [GOOD_W-1:0] goodCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lockedQ  <= 1'b0;
      errFlagQ <= 1'b0;
      goodCnt  <= '0;
    end else if (bitEn) begin
      errFlagQ <= lockedQ && bitErr;
      if (!lockedQ) begin
        if (bitErr || stateZero) begin
          goodCnt <= '0;
        end else if (goodCnt == GOOD_W'(LOCK_RUN - 1)) begin
          lockedQ <= 1'b1;
          goodCnt <= '0;
        end else begin
          goodCnt <= goodCnt + 1'b1;
        end
      end else if (winLoss) begin
        lockedQ <= 1'b0;
        goodCnt <= '0;
      end
    end
  end

  always_comb begin
    ctl.hunt     = !lockedQ;
    ctl.countErr = bitEn && lockedQ && bitErr && cntEnable;
    errOut       = !lockedQ || errFlagQ;
  end

  assert_lock_run_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lockedQ) |-> $past(goodCnt) == GOOD_W'(LOCK_RUN - 1));

  assert_zero_no_lock_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lockedQ) |-> !$past(stateZero));
endmodule

// File: rtl/prbs_sync_mon.sv
module prbs_sync_mon
  import prbs_mon_pkg::*;
#(
  parameter int LOCK_RUN  = 32,
  parameter int WIN_LEN   = 64,
  parameter int LOSS_LIM  = 6,
  parameter int FORCE_RUN = 14,
  parameter int CNT_W     = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bitEn,
  input  logic             modeT1,
  input  logic             rxData,
  input  logic             cntEnable,
  input  logic             latchStb,
  output logic             errOut,
  output logic [CNT_W-1:0] errCount
);
  monCtl_t ctl;
  logic    bitErr;
  logic    stateZero;
  logic    winLoss;

  prbs_mon_dpath #(
    .WIN_LEN(WIN_LEN), .LOSS_LIM(LOSS_LIM), .FORCE_RUN(FORCE_RUN), .CNT_W(CNT_W)
  ) uDpath (
    .clk(clk), .rstN(rstN), .bitEn(bitEn), .modeT1(modeT1), .rxData(rxData),
    .latchStb(latchStb), .ctl(ctl), .bitErr(bitErr), .stateZero(stateZero),
    .winLoss(winLoss), .errCount(errCount)
  );

  prbs_mon_ctrl #(.LOCK_RUN(LOCK_RUN)) uCtrl (
    .clk(clk), .rstN(rstN), .bitEn(bitEn), .cntEnable(cntEnable),
    .bitErr(bitErr), .stateZero(stateZero), .winLoss(winLoss),
    .ctl(ctl), .errOut(errOut)
  );
endmodule

// File: tb/sim_prbs_sync_mon.sv
`timescale 1ns/1ps
module sim_prbs_sync_mon;
  localparam int CW = 6;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          bitEn = 1'b0;
  logic          modeT1 = 1'b0;
  logic          rxData = 1'b0;
  logic          cntEnable = 1'b0;
  logic          latchStb = 1'b0;
  logic          errOut;
  logic [CW-1:0] errCount;

  int   checks = 0;
  int   failures = 0;
  logic genT1 = 1'b0;
  logic [19:0] genSt = 20'h0;
  int   genRun = 0;
  int   forcedSeen = 0;
  logic obs;

  always #2 clk = ~clk;

  prbs_sync_mon #(.CNT_W(CW)) u0 (
    .clk(clk), .rstN(rstN), .bitEn(bitEn), .modeT1(modeT1), .rxData(rxData),
    .cntEnable(cntEnable), .latchStb(latchStb), .errOut(errOut), .errCount(errCount)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // reference pattern source, built from the requirement text
  task automatic genBit(output logic o);
    logic s;
    s = genT1 ? (genSt[16] ^ genSt[19]) : (genSt[13] ^ genSt[14]);
    o = (genT1 && genRun >= 14) ? 1'b1 : s;
    if (genT1 && genRun >= 14 && !s) forcedSeen++;
    genSt = {genSt[18:0], s};
    genRun = o ? 0 : genRun + 1;
  endtask

  task automatic sendBit(input logic flip);
    logic b;
    genBit(b);
    rxData = b ^ flip;
    bitEn = 1'b1;
    @(negedge clk);
    obs = errOut;
  endtask

  task automatic sendClean(input int n, output int highs);
    highs = 0;
    for (int i = 0; i < n; i++) begin
      sendBit(1'b0);
      if (obs) highs++;
    end
  endtask

  task automatic rawBit(input logic b);
    rxData = b;
    bitEn = 1'b1;
    @(negedge clk);
    obs = errOut;
  endtask

  task automatic doLatch();
    bitEn = 1'b0;
    latchStb = 1'b1;
    @(negedge clk);
    latchStb = 1'b0;
  endtask

  task automatic resetDut(input logic t1, input logic [19:0] seed);
    bitEn = 1'b0;
    rstN = 1'b0;
    modeT1 = t1;
    genT1 = t1;
    genSt = seed;
    genRun = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    resetDut(1'b0, 20'h0ACE1);
    chk("R1 errOut after reset", errOut, 1);
    chk("R1 errCount after reset", errCount, 0);
  endtask

  task automatic t_e1Lock();
    int h;
    resetDut(1'b0, 20'h0ACE1);
    sendClean(31, h);
    chk("R2 unlocked after 31 bits", obs, 1);
    sendClean(16, h);
    chk("R2 locked after 47 bits", obs, 0);
  endtask

  task automatic t_singleErr();
    int h;
    sendClean(10, h);
    sendBit(1'b1);
    chk("R4 pulse on flipped bit", obs, 1);
    sendBit(1'b0);
    chk("R4 pulse ends next bit", obs, 0);
    sendClean(5, h);
    chk("R4 no follow-on errors", h, 0);
  endtask

  task automatic t_window();
    int h;
    sendClean(70, h);
    for (int i = 0; i < 5; i++) begin
      sendBit(1'b1);
      sendBit(1'b0);
    end
    sendClean(10, h);
    chk("R5 lock kept with 5 errors", obs, 0);
    sendClean(70, h);
    for (int i = 0; i < 6; i++) begin
      sendBit(1'b1);
      if (i < 5) sendBit(1'b0);
    end
    chk("R5 high at 6th error", obs, 1);
    sendClean(31, h);
    chk("R5 lock dropped, still hunting after 31", obs, 1);
    sendClean(1, h);
    chk("R6 relock on 32nd good bit", obs, 0);
  endtask

  task automatic t_counter();
    int h;
    resetDut(1'b0, 20'h05A5A);
    cntEnable = 1'b1;
    sendClean(60, h);
    doLatch();
    chk("R8 hunt errors not counted", errCount, 0);
    for (int i = 0; i < 3; i++) begin
      sendBit(1'b1);
      sendClean(20, h);
    end
    doLatch();
    chk("R8 three errors latched", errCount, 3);
    doLatch();
    chk("R8 latch cleared counter", errCount, 0);
    cntEnable = 1'b0;
    for (int i = 0; i < 2; i++) begin
      sendBit(1'b1);
      sendClean(20, h);
    end
    doLatch();
    chk("R8 disabled counting", errCount, 0);
  endtask

  task automatic t_saturate();
    int h;
    cntEnable = 1'b1;
    doLatch();
    for (int i = 0; i < 70; i++) begin
      sendBit(1'b1);
      sendClean(12, h);
    end
    chk("R5 lock kept at 5 per 64", obs, 0);
    doLatch();
    chk("R9 counter saturated", errCount, (1 << CW) - 1);
    cntEnable = 1'b0;
  endtask

  task automatic t_zeros();
    int lows;
    for (int m = 0; m < 2; m++) begin
      resetDut(m[0], 20'h00001);
      lows = 0;
      for (int i = 0; i < 200; i++) begin
        rawBit(1'b0);
        if (!obs) lows++;
      end
      chk(m == 0 ? "R7 zeros no lock E1" : "R7 zeros no lock T1", lows, 0);
    end
  endtask

  task automatic t_qrss();
    int h;
    logic [19:0] st;
    st = 20'h00001;
    for (int i = 0; i < 120; i++) st = {st[0] ^ st[17], st[19:1]};
    resetDut(1'b1, st);
    forcedSeen = 0;
    sendClean(52, h);
    chk("R3 T1 locked within 52 bits", obs, 0);
    sendClean(150, h);
    chk("R3 no errors across forced ones", h, 0);
    chk("R3 stimulus contained forced ones", forcedSeen > 0 ? 1 : 0, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_e1Lock();
    t_singleErr();
    t_window();
    t_counter();
    t_saturate();
    t_zeros();
    t_qrss();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule